// File: doc/BRIEF.md
# Cache Way Retirement Controller

This block watches correctable and uncorrectable error reports for the ways of a set-associative cache. It keeps a small leaky counter for each way. A way is taken out of service when its correctable errors arrive faster than a periodic decay tick can drain them, or at once when an uncorrectable error hits it. Ways leave service one at a time. The lookup and replacement logic reads the resulting enable mask and must skip any way whose bit is low.

When the last usable way is retired, the mask is all zero and the block raises a request to isolate the whole chip. That request holds until reset. A one-cycle interrupt pulse marks every retirement, and a count of retired ways is kept alongside the mask. The number of ways is a parameter: 12 for a second-level cache, 2 for a first-level cache, and 10 for a reduced variant.

Top module: `way_retire_ctrl`

## Requirements
- R1: After reset all ways are enabled (`way_en` all ones), every counter is zero, `dead_cnt` is 0, and `isolate` and `irq` are low.
- R2: A correctable event (`err_valid` high, `err_fatal` low) on an enabled way adds one to that way's counter. The counter saturates at 2^CW-1. `decay_tick` subtracts one from each nonzero counter. A correctable event and a tick in the same cycle leave that way's counter unchanged. Correction alone, with the counter below threshold, never disables a way.
- R3: A way whose counter is at or above a nonzero `thresh` is retired at the next clock edge, and its counter is cleared. A `thresh` of 0 turns off retirement by count.
- R4: At most one way is retired per clock edge. An uncorrectable event takes priority. Among ways over the threshold, the lowest index goes first, and the others follow on later edges.
- R5: An uncorrectable event (`err_fatal` high) on an enabled way retires that way at the same edge that samples the event.
- R6: Events that name a way already retired, or an index of WAYS or more, have no effect on the mask, the counters or the flags.
- R7: Retiring a way leaves all other ways enabled. A retired way stays off until reset. `dead_cnt` always equals the number of retired ways.
- R8: `irq` is high for exactly the one cycle that follows each retirement edge.
- R9: When the last enabled way is retired, `way_en` becomes all zero and `isolate` rises. `isolate` then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_valid | input | 1 | An error event is present this cycle |
| err_way | input | $clog2(WAYS) | Way index of the event |
| err_fatal | input | 1 | 1 = uncorrectable, 0 = corrected single-bit |
| decay_tick | input | 1 | Periodic pulse that drains the counters |
| thresh | input | CW | Retirement threshold (0 = count retirement off) |
| way_en | output | WAYS | Per-way enable mask, 1 = in service |
| dead_cnt | output | $clog2(WAYS)+1 | Number of retired ways |
| isolate | output | 1 | Sticky request to isolate the chip |
| irq | output | 1 | One-cycle pulse after each retirement |

## Verification
The bench first raises the threshold so that two ways sit at the same count, then lowers it so both qualify at once. A design without a priority pick would drop both ways on one edge or take the higher index first. In another case, an uncorrectable event arrives in the same cycle that a different way crosses the threshold. A design that got this wrong would retire the counted way first, or retire both together. A long burst of errors on one way with count retirement off checks saturation: a wrapping counter would hold a small value and miss a later threshold of 15. The bench also checks that a tick and an error in the same cycle cancel, that events on retired or out-of-range ways change nothing, and that `isolate` stays set after the last way is gone and clears only on reset.

// File: rtl/way_retire_ctrl.sv
module way_retire_ctrl #(
  parameter int WAYS = 12,
  parameter int CW   = 4,
  parameter int IW   = $clog2(WAYS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            err_valid,
  input  logic [IW-1:0]   err_way,
  input  logic            err_fatal,
  input  logic            decay_tick,
  input  logic [CW-1:0]   thresh,
  output logic [WAYS-1:0] way_en,
  output logic [IW:0]     dead_cnt,
  output logic            isolate,
  output logic            irq
);

  logic [CW-1:0]   cnt [WAYS];
  logic [WAYS-1:0] hit, cand;
  logic            fat_hit, ret;
  logic [IW-1:0]   sel;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic inc, dec;
    assign hit[w]  = err_valid && (err_way == IW'(w)) && way_en[w];
    assign cand[w] = way_en[w] && (thresh != '0) && (cnt[w] >= thresh);
    assign inc     = hit[w] && !err_fatal;
    assign dec     = decay_tick && (cnt[w] != '0);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                           cnt[w] <= '0;
      else if (ret && sel == IW'(w))        cnt[w] <= '0;
      else if (inc && !dec && cnt[w] != '1) cnt[w] <= cnt[w] + 1'b1;
      else if (dec && !inc)                 cnt[w] <= cnt[w] - 1'b1;
  end

  assign fat_hit = err_fatal && (|hit);

  always_comb begin
    ret = 1'b0;
    sel = '0;
    if (fat_hit) begin
      ret = 1'b1;
      for (int w = 0; w < WAYS; w++)
        if (hit[w]) sel = IW'(w);
    end else begin
      for (int w = WAYS - 1; w >= 0; w--)
        if (cand[w]) begin
          ret = 1'b1;
          sel = IW'(w);
        end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      way_en   <= '1;
      dead_cnt <= '0;
      isolate  <= 1'b0;
      irq      <= 1'b0;
    end else begin
      irq <= ret;
      if (ret) begin
        way_en[sel] <= 1'b0;
        dead_cnt    <= dead_cnt + 1'b1;
        if (way_en == (WAYS'(1) << sel)) isolate <= 1'b1;
      end
    end

  assert_one_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones($past(way_en) & ~way_en) <= 1);

  assert_no_revive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (way_en & ~$past(way_en)) == '0);

  assert_dead_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(dead_cnt) == WAYS - $countones(way_en));

  assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (way_en != $past(way_en)));

  assert_isolate_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    isolate |=> isolate);

  assert_isolate_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    isolate == (way_en == '0));

endmodule

// File: tb/way_retire_ctrl_bench.sv
`timescale 1ns/1ps
module way_retire_ctrl_bench;
  localparam int WAYS = 12, CW = 4, IW = 4;

  logic clk = 0, rst_n = 0;
  logic err_valid = 0, err_fatal = 0, decay_tick = 0;
  logic [IW-1:0] err_way = '0;
  logic [CW-1:0] thresh = 4'd2;
  logic [WAYS-1:0] way_en;
  logic [IW:0] dead_cnt;
  logic isolate, irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  way_retire_ctrl #(.WAYS(WAYS), .CW(CW), .IW(IW)) u_way_retire_ctrl (
    .clk, .rst_n, .err_valid, .err_way, .err_fatal, .decay_tick, .thresh,
    .way_en, .dead_cnt, .isolate, .irq);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(logic v, logic f, logic t, logic [IW-1:0] w);
    @(negedge clk);
    err_valid = v; err_fatal = f; decay_tick = t; err_way = w;
  endtask

  task automatic idle();
    @(negedge clk);
    err_valid = 0; err_fatal = 0; decay_tick = 0;
  endtask

  task automatic step(logic v, logic f, logic t, logic [IW-1:0] w);
    drive(v, f, t, w);
    @(posedge clk);
    idle();
    @(posedge clk); #1;
  endtask

  // {valid, fatal, tick, way[3:0], mask[11:0], dead[3:0]}, threshold 2
  localparam logic [22:0] VEC [10] = '{
    {1'b1, 1'b0, 1'b0, 4'd3,  12'hFFF, 4'd0},  // R2 one error, below threshold
    {1'b1, 1'b0, 1'b0, 4'd3,  12'hFF7, 4'd1},  // R3 threshold reached
    {1'b1, 1'b0, 1'b0, 4'd3,  12'hFF7, 4'd1},  // R6 retired way
    {1'b1, 1'b0, 1'b0, 4'd5,  12'hFF7, 4'd1},  // R2
    {1'b0, 1'b0, 1'b1, 4'd0,  12'hFF7, 4'd1},  // R2 decay
    {1'b1, 1'b0, 1'b0, 4'd5,  12'hFF7, 4'd1},  // R2 decay took effect
    {1'b1, 1'b1, 1'b0, 4'd0,  12'hFF6, 4'd2},  // R5 uncorrectable
    {1'b1, 1'b1, 1'b0, 4'd0,  12'hFF6, 4'd2},  // R6 retired way
    {1'b1, 1'b0, 1'b0, 4'd11, 12'hFF6, 4'd2},  // R2
    {1'b1, 1'b0, 1'b0, 4'd11, 12'h7F6, 4'd3}   // R3 R7 others stay
  };

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    if (!done) $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 mask", way_en, 32'hFFF);
    chk("R1 dead", dead_cnt, 0);
    chk("R1 isolate", isolate, 0);
    chk("R1 irq", irq, 0);
    @(negedge clk) rst_n = 1;

    for (int i = 0; i < 10; i++) begin
      step(VEC[i][22], VEC[i][21], VEC[i][20], VEC[i][19:16]);
      chk($sformatf("R2/R3/R5/R6 vec%0d mask", i), way_en, VEC[i][15:4]);
      chk($sformatf("R7 vec%0d dead", i), dead_cnt, {1'b0, VEC[i][3:0]});
    end

    // R8 irq pulse
    drive(1, 1, 0, 4'd4);
    @(posedge clk); #1;
    chk("R5 way4 off", way_en[4], 0);
    chk("R8 irq high", irq, 1);
    idle();
    @(posedge clk); #1;
    chk("R8 irq one cycle", irq, 0);

    // R4 lowest index first
    @(negedge clk) thresh = 4'd4;
    step(1, 0, 0, 4'd7); step(1, 0, 0, 4'd7);
    step(1, 0, 0, 4'd2); step(1, 0, 0, 4'd2);
    chk("R2 below thresh", way_en, 32'h7E6);
    @(negedge clk) thresh = 4'd2;
    @(posedge clk); #1;
    chk("R4 first pick", way_en[2] * 2 + way_en[7], 1);
    @(posedge clk); #1;
    chk("R4 second pick", way_en, 32'h762);
    chk("R7 dead", dead_cnt, 6);

    // R4 uncorrectable wins over a count candidate
    @(negedge clk) thresh = 4'd3;
    step(1, 0, 0, 4'd5);
    chk("R2 way5 at 2", way_en[5], 1);
    drive(1, 1, 0, 4'd9);
    thresh = 4'd2;
    @(posedge clk); #1;
    chk("R4 fatal first", way_en[9] * 2 + way_en[5], 1);
    idle();
    @(posedge clk); #1;
    chk("R4 candidate next", way_en, 32'h542);

    // R2 saturation with count retirement off, R6 out-of-range index
    @(negedge clk) thresh = 4'd0;
    drive(1, 0, 0, 4'd1);
    repeat (20) @(posedge clk);
    idle();
    @(posedge clk); #1;
    chk("R3 thresh zero", way_en, 32'h542);
    step(1, 1, 0, 4'd13);
    chk("R6 index range", way_en, 32'h542);
    chk("R6 irq", irq, 0);
    @(negedge clk) thresh = 4'd15;
    @(posedge clk); #1;
    chk("R2 saturated", way_en, 32'h540);

    // R9 isolation
    step(1, 1, 0, 4'd6);
    step(1, 1, 0, 4'd8);
    chk("R9 not yet", isolate, 0);
    step(1, 1, 0, 4'd10);
    chk("R9 mask empty", way_en, 0);
    chk("R9 isolate", isolate, 1);
    chk("R7 dead all", dead_cnt, 12);
    repeat (5) @(posedge clk);
    #1;
    chk("R9 sticky", isolate, 1);
    @(negedge clk) rst_n = 0;
    @(posedge clk); #1;
    chk("R1 mask after reset", way_en, 32'hFFF);
    chk("R1 isolate cleared", isolate, 0);
    @(negedge clk) rst_n = 1;

    // R2 error and tick together cancel
    @(negedge clk) thresh = 4'd2;
    step(1, 0, 0, 4'd0);
    step(1, 0, 1, 4'd0);
    chk("R2 cancel", way_en[0], 1);
    step(1, 0, 0, 4'd0);
    chk("R3 after cancel", way_en[0], 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule